// File: doc/BRIEF.md
# Power-Off Pin Pattern Sequencer

This block walks a small group of general-purpose output pins through a programmed series of patterns, so that an external power-management device can be signalled to remove system power. Before it runs, a simple write port loads the number of controlled pins, the bit position of each pin inside one shared 32-bit output word, one pattern per step, a delay in milliseconds and a prescaler that gives the number of clock cycles per millisecond.

When a start is accepted, the block first switches every controlled pin to GPIO function and to output drive. It then waits one full delay and applies the steps in order, waiting the delay again after each one. Each step changes only the controlled pins and leaves every other bit of the output word as it was. The last step is computed but is not driven. Its word is held on a separate output and is copied to the pins only when the later `fire` pulse arrives. This lets the system finish its other shutdown work (for example, putting memory into self-refresh) before the final edge cuts power.

Top module: `pmic_step_seq`

## Requirements
- R1: After reset, `gpio_out` is 0, `gpio_oe_n` and `gpio_mux` are all ones, and `busy`, `done`, `final_valid` and `start_err` are 0.
- R2: Register writes (`cfg_we` with `cfg_addr`/`cfg_wdata`) take effect only while `busy` is low. The map is:
  - 0x00: bit 0 set requests a start.
  - 0x01: pin count, from `cfg_wdata[7:0]`.
  - 0x02: step count, from `cfg_wdata[7:0]`.
  - 0x03: delay in ms, from `cfg_wdata[7:0]`.
  - 0x04: cycles per ms, from `cfg_wdata[15:0]`.
  - 0x05: output word.
  - 0x10+i: bit index of pin i, from `cfg_wdata[4:0]`.
  - 0x20+j: pattern of step j, from `cfg_wdata[MAX_PINS-1:0]`.
- R3: A start is rejected when the pin count is at least MAX_PINS, when the step count is at least MAX_STEPS, or when the step count is 0. A rejected start raises `start_err` for one cycle, keeps `busy` low and changes no other output.
- R4: On the clock edge after an accepted start, for each pin i below the pin count, bit `idx_i` of `gpio_oe_n` is cleared (0 means drive) and the 4-bit field `gpio_mux[4*idx_i+3:4*idx_i]` is cleared (GPIO function). All other bits keep their values.
- R5: Let T = delay_ms × cycles_per_ms. Step k (counted from 0) is applied (k+1)·(T+1) clock edges after the configuration edge.
- R6: A step word starts from the current `gpio_out`. For each pin i below the pin count, bit `idx_i` is set to bit i of the step pattern (0 low, 1 high). Every other bit is unchanged. Steps 0 to N-2 are written to `gpio_out`.
- R7: Step N-1 is not written to the pins. It appears on `final_word` with `final_valid` high. On an edge where `fire` is high and `final_valid` is high, `gpio_out` takes `final_word` and `final_valid` clears. At any other time, `fire` has no effect.
- R8: `busy` rises on the accepted start edge and falls on the edge where `final_valid` rises. `done` is high for exactly that one cycle.
- R9: An accepted start clears a pending final word: `final_valid` drops on the start edge.
- R10: A write to 0x05 while idle loads `gpio_out` on that edge. If `fire` applies a pending word on the same edge, `fire` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 32 | Register write data |
| fire | input | 1 | Releases the held final word onto the pins |
| gpio_out | output | 32 | Shared output data word |
| gpio_oe_n | output | 32 | Output enable word, 0 drives |
| gpio_mux | output | 128 | Four-bit function field per pin, 0 selects GPIO |
| final_word | output | 32 | Held value of the last step |
| final_valid | output | 1 | Final word is pending |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the final word becomes pending |
| start_err | output | 1 | One-cycle pulse on a rejected start |

## Verification
The bench targets four corner cases.

- **Step timing.** It checks the exact cycle of the first pattern edge. A design that skipped the delay after configuration, or counted T instead of T+1 cycles, would move `gpio_out` one step early.
- **Final step held back.** It checks that the last pattern stays off the pins until `fire`. A design that drove it would show the final word on `gpio_out` while `final_valid` is still high.
- **Writes and fire at the wrong time.** It writes patterns and counts while busy, fires while nothing is pending, and fires in the same cycle as a direct write. Wrong gating would corrupt the held word or let the direct write override it.
- **Boundary counts.** It starts with out-of-range counts, with a step count of zero, and with a one-step, zero-delay run. Off-by-one limit checks would start when they should reject, or mishandle the case where the only step is the final one.

// File: rtl/pmic_step_seq.sv
`timescale 1ns/1ps
module pmic_step_seq #(
  parameter int MAX_PINS  = 8,
  parameter int MAX_STEPS = 8,
  parameter int DLY_W     = 8,
  parameter int PRE_W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [7:0]   cfg_addr,
  input  logic [31:0]  cfg_wdata,
  input  logic         fire,
  output logic [31:0]  gpio_out,
  output logic [31:0]  gpio_oe_n,
  output logic [127:0] gpio_mux,
  output logic [31:0]  final_word,
  output logic         final_valid,
  output logic         busy,
  output logic         done,
  output logic         start_err
);
  localparam int T_W    = DLY_W + PRE_W;
  localparam int PIDX_W = (MAX_PINS > 1) ? $clog2(MAX_PINS) : 1;
  localparam int SIDX_W = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_CFG, S_WAIT} state_t;
  state_t state;

  logic [7:0]          pin_cnt, step_cnt, step;
  logic [DLY_W-1:0]    dly_ms;
  logic [PRE_W-1:0]    pre_cyc;
  logic [4:0]          pin_idx [MAX_PINS];
  logic [MAX_PINS-1:0] pat     [MAX_STEPS];
  logic [T_W-1:0]      cnt, dly_total;
  logic [31:0]         cfg_mask, step_word;
  logic [127:0]        mux_mask;
  logic                wr, start_req, cnt_ok, last;

  assign wr        = cfg_we && !busy;
  assign start_req = wr && cfg_addr == 8'h00 && cfg_wdata[0];
  assign cnt_ok    = (32'(pin_cnt) < MAX_PINS) && (32'(step_cnt) < MAX_STEPS) && step_cnt != 8'd0;
  assign dly_total = T_W'(dly_ms) * T_W'(pre_cyc);
  assign last      = (step == step_cnt - 8'd1);

  always_comb begin
    cfg_mask  = '0;
    mux_mask  = '0;
    step_word = gpio_out;
    for (int i = 0; i < MAX_PINS; i++)
      if (i < 32'(pin_cnt)) begin
        cfg_mask[pin_idx[i]]              = 1'b1;
        mux_mask[{pin_idx[i], 2'b00} +: 4] = 4'hF;
        step_word[pin_idx[i]]             = pat[step[SIDX_W-1:0]][i];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_cnt  <= '0;
      step_cnt <= '0;
      dly_ms   <= '0;
      pre_cyc  <= '0;
      for (int i = 0; i < MAX_PINS; i++)  pin_idx[i] <= '0;
      for (int j = 0; j < MAX_STEPS; j++) pat[j]     <= '0;
    end else if (wr) begin
      case (cfg_addr)
        8'h01:   pin_cnt  <= cfg_wdata[7:0];
        8'h02:   step_cnt <= cfg_wdata[7:0];
        8'h03:   dly_ms   <= cfg_wdata[DLY_W-1:0];
        8'h04:   pre_cyc  <= cfg_wdata[PRE_W-1:0];
        default: begin
          if (cfg_addr[7:4] == 4'h1 && 32'(cfg_addr[3:0]) < MAX_PINS)
            pin_idx[cfg_addr[PIDX_W-1:0]] <= cfg_wdata[4:0];
          if (cfg_addr[7:4] == 4'h2 && 32'(cfg_addr[3:0]) < MAX_STEPS)
            pat[cfg_addr[SIDX_W-1:0]] <= cfg_wdata[MAX_PINS-1:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      gpio_out    <= '0;
      gpio_oe_n   <= '1;
      gpio_mux    <= '1;
      final_word  <= '0;
      final_valid <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      start_err   <= 1'b0;
      cnt         <= '0;
      step        <= '0;
    end else begin
      done      <= 1'b0;
      start_err <= 1'b0;
      if (start_req) begin
        if (cnt_ok) begin
          state       <= S_CFG;
          busy        <= 1'b1;
          final_valid <= 1'b0;
        end else begin
          start_err <= 1'b1;
        end
      end
      if (wr && cfg_addr == 8'h05) gpio_out <= cfg_wdata;
      if (fire && final_valid) begin
        gpio_out    <= final_word;
        final_valid <= 1'b0;
      end
      case (state)
        S_CFG: begin
          gpio_oe_n <= gpio_oe_n & ~cfg_mask;
          gpio_mux  <= gpio_mux & ~mux_mask;
          cnt       <= dly_total;
          step      <= '0;
          state     <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (!last) begin
            gpio_out <= step_word;
            step     <= step + 8'd1;
            cnt      <= dly_total;
          end else begin
            final_word  <= step_word;
            final_valid <= 1'b1;
            busy        <= 1'b0;
            done        <= 1'b1;
            state       <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pmic_step_seq_chk.sv
`timescale 1ns/1ps
module pmic_step_seq_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         fire,
  input logic [31:0]  gpio_out,
  input logic [31:0]  gpio_oe_n,
  input logic [127:0] gpio_mux,
  input logic [31:0]  final_word,
  input logic         final_valid,
  input logic         busy,
  input logic         done,
  input logic         start_err
);
  assert_done_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && final_valid));

  assert_pending_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    final_valid |-> !busy);

  assert_fire_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && final_valid) |=> (gpio_out == $past(final_word) && !final_valid));

  assert_oe_only_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_oe_n & ~$past(gpio_oe_n)) == 32'h0));

  assert_mux_only_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_mux & ~$past(gpio_mux)) == 128'h0));

  assert_reject_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> !busy);
endmodule

bind pmic_step_seq pmic_step_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fire(fire), .gpio_out(gpio_out),
  .gpio_oe_n(gpio_oe_n), .gpio_mux(gpio_mux), .final_word(final_word),
  .final_valid(final_valid), .busy(busy), .done(done), .start_err(start_err)
);

// File: tb/pmic_step_seq_tb_top.sv
`timescale 1ns/1ps
module pmic_step_seq_tb_top;
  localparam int NP = 8;
  localparam int NS = 8;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, fire = 1'b0;
  logic [7:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  gpio_out, gpio_oe_n, final_word;
  logic [127:0] gpio_mux;
  logic         final_valid, busy, done, start_err;

  always #10 clk = ~clk;

  pmic_step_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fire(fire), .gpio_out(gpio_out), .gpio_oe_n(gpio_oe_n), .gpio_mux(gpio_mux),
    .final_word(final_word), .final_valid(final_valid), .busy(busy), .done(done),
    .start_err(start_err)
  );

  int vectors = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0]   m_out, m_oe, m_fw, m_w;
  logic [127:0]  m_mux;
  bit            m_busy, m_done, m_err, m_fv, ob, ofv;
  int            m_state, m_cnt, m_step, m_pc, m_sc, m_dly, m_pre;
  int            m_idx [NP];
  logic [NP-1:0] m_pat [NS];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = '0; m_oe = '1; m_mux = '1; m_fw = '0;
      m_busy = 0; m_done = 0; m_err = 0; m_fv = 0;
      m_state = 0; m_cnt = 0; m_step = 0; m_pc = 0; m_sc = 0; m_dly = 0; m_pre = 0;
      for (int i = 0; i < NP; i++) m_idx[i] = 0;
      for (int j = 0; j < NS; j++) m_pat[j] = '0;
    end else begin
      ob = m_busy; ofv = m_fv; m_done = 0; m_err = 0;
      if (m_state == 1) begin
        for (int i = 0; i < m_pc; i++) begin
          m_oe[m_idx[i]] = 1'b0;
          m_mux[4*m_idx[i] +: 4] = 4'h0;
        end
        m_cnt = m_dly * m_pre; m_step = 0; m_state = 2;
      end else if (m_state == 2) begin
        if (m_cnt > 0) m_cnt--;
        else begin
          m_w = m_out;
          for (int i = 0; i < m_pc; i++) m_w[m_idx[i]] = m_pat[m_step][i];
          if (m_step < m_sc - 1) begin
            m_out = m_w; m_step++; m_cnt = m_dly * m_pre;
          end else begin
            m_fw = m_w; m_fv = 1; m_busy = 0; m_done = 1; m_state = 0;
          end
        end
      end
      if (cfg_we && !ob) begin
        case (cfg_addr)
          8'h00: if (cfg_wdata[0]) begin
                   if (m_pc < NP && m_sc < NS && m_sc != 0) begin
                     m_state = 1; m_busy = 1; m_fv = 0;
                   end else m_err = 1;
                 end
          8'h01: m_pc  = int'(cfg_wdata[7:0]);
          8'h02: m_sc  = int'(cfg_wdata[7:0]);
          8'h03: m_dly = int'(cfg_wdata[7:0]);
          8'h04: m_pre = int'(cfg_wdata[15:0]);
          8'h05: m_out = cfg_wdata;
          default: begin
            if (cfg_addr >= 8'h10 && cfg_addr < 8'h10 + NP) m_idx[cfg_addr - 8'h10] = int'(cfg_wdata[4:0]);
            if (cfg_addr >= 8'h20 && cfg_addr < 8'h20 + NS) m_pat[cfg_addr - 8'h20] = cfg_wdata[NP-1:0];
          end
        endcase
      end
      if (fire && ofv) begin m_out = m_fw; m_fv = 0; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6 gpio_out", gpio_out, m_out);
      chk("R4 gpio_oe_n", gpio_oe_n, m_oe);
      chk("R4 gpio_mux", gpio_mux, m_mux);
      chk("R8 busy", busy, m_busy);
      chk("R8 done", done, m_done);
      chk("R7 final_valid", final_valid, m_fv);
      if (m_fv) chk("R7 final_word", final_word, m_fw);
      chk("R3 start_err", start_err, m_err);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fire();
    fire = 1'b1;
    @(negedge clk);
    fire = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk("R8 done seen", done, 1'b1);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 out", gpio_out, 32'h0);
    chk("R1 oe", gpio_oe_n, 32'hFFFF_FFFF);
    chk("R1 mux", gpio_mux, {128{1'b1}});
    chk("R1 busy", busy, 1'b0);
    chk("R1 final_valid", final_valid, 1'b0);

    // main run: pins 3,17,31; four steps; T = 2*3 = 6
    wr(8'h05, 32'h0000_FFFF);
    wr(8'h10, 3); wr(8'h11, 17); wr(8'h12, 31);
    wr(8'h01, 3); wr(8'h02, 4);
    wr(8'h20, 3'b101); wr(8'h21, 3'b010); wr(8'h22, 3'b111); wr(8'h23, 3'b000);
    wr(8'h03, 2); wr(8'h04, 3);
    wr(8'h00, 1);
    chk("R8 busy after start", busy, 1'b1);
    idle(1);
    chk("R4 oe cleared", gpio_oe_n, 32'h7FFD_FFF7);
    chk("R4 mux pin field", gpio_mux[12 +: 4], 4'h0);
    chk("R4 mux other field", gpio_mux[16 +: 4], 4'hF);
    idle(6);
    chk("R5 before first step", gpio_out, 32'h0000_FFFF);
    idle(1);
    chk("R5 first step", gpio_out, 32'h8000_FFFF);
    wait_done();
    chk("R7 last not driven", gpio_out, 32'h8002_FFFF);
    chk("R7 held word", final_word, 32'h0000_FFF7);
    pulse_fire();
    chk("R7 fire drives", gpio_out, 32'h0000_FFF7);
    chk("R7 pending cleared", final_valid, 1'b0);
    pulse_fire();
    chk("R7 fire without pending", gpio_out, 32'h0000_FFF7);

    // R3 rejections
    wr(8'h01, 8); wr(8'h00, 1);
    chk("R3 pin count limit", start_err, 1'b1);
    chk("R3 stays idle", busy, 1'b0);
    wr(8'h01, 3); wr(8'h02, 8); wr(8'h00, 1);
    chk("R3 step count limit", start_err, 1'b1);
    wr(8'h02, 0); wr(8'h00, 1);
    chk("R3 zero steps", start_err, 1'b1);
    chk("R3 oe untouched", gpio_oe_n, 32'h7FFD_FFF7);

    // R10 direct load, R2 writes ignored while busy
    wr(8'h05, 32'h1234_0000);
    chk("R10 direct load", gpio_out, 32'h1234_0000);
    wr(8'h02, 2); wr(8'h03, 1); wr(8'h04, 2);
    wr(8'h00, 1);
    wr(8'h21, 0); wr(8'h01, 1); wr(8'h05, 32'hDEAD_BEEF);
    pulse_fire();
    wait_done();
    chk("R2 busy writes ignored", final_word, 32'h1236_0000);
    chk("R6 step kept other bits", gpio_out, 32'h9234_0008);

    // R9 restart drops pending word
    wr(8'h00, 1);
    chk("R9 pending dropped", final_valid, 1'b0);
    chk("R9 busy again", busy, 1'b1);
    wait_done();
    chk("R9 new held word", final_word, 32'h1236_0000);

    // R10 fire beats a same-cycle direct load
    cfg_we = 1'b1; cfg_addr = 8'h05; cfg_wdata = 32'hCAFE_F00D; fire = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; fire = 1'b0;
    chk("R10 fire priority", gpio_out, 32'h1236_0000);

    // R5 single step, zero delay
    wr(8'h02, 1); wr(8'h03, 0);
    wr(8'h00, 1);
    idle(1);
    chk("R5 not yet pending", final_valid, 1'b0);
    idle(1);
    chk("R5 zero delay pending", final_valid, 1'b1);
    chk("R7 single step held", final_word, 32'h9234_0008);
    chk("R7 single step not driven", gpio_out, 32'h1236_0000);
    idle(2);
    summary();
  end
endmodule